// File: doc/BRIEF.md
# Transmit Buffer Descriptor Sequencer

This block feeds a downstream serial framer from a ring of transmit buffer descriptors kept in a small on-block register table. Each descriptor carries four flags (ready, last, interrupt, wrap), a byte count, a start address into an on-block byte store and a two-bit status field. Software loads descriptors and buffer bytes through two simple write ports. The sequencer polls the descriptor it points at. Once that descriptor is ready, it streams the buffer to the framer over a valid/ready byte channel and flags the final byte of a frame.

A frame may be split across several consecutive buffers. Only the buffer that carries the last flag closes the frame. The sequencer then waits for the framer to report that the closing flag is out, writes the frame status and releases the descriptor. A buffer that does not close a frame is only released. Each descriptor selects for itself whether its completion raises an interrupt pulse, so software can be told about every buffer, every frame or a chosen group of frames. If the framer is still waiting for data between two buffers of one frame and the next descriptor is not ready, the frame is aborted and an underrun is recorded.

Top module: `txbd_sequencer`

## Requirements
- R1: During and right after reset no byte is offered, no interrupt or abort is raised, every descriptor reads back not ready with status 00, and polling starts at descriptor 0.
- R2: While the polled descriptor is not ready, out_valid stays low. Once it is ready, its bytes are offered in order from its start address upward (modulo the byte store size), exactly as many as its length. A byte stays on offer until out_ready is seen high.
- R3: out_last is high only together with the final byte of a buffer whose last flag is set.
- R4: A buffer whose last flag is clear is released one cycle after its final byte is taken: ready reads back 0, its status is left unchanged, and the frame continues with the next descriptor.
- R5: A buffer whose last flag is set keeps its ready flag until close_done is seen high. In that cycle it is released and its status becomes 01 (frame sent).
- R6: Releasing a descriptor whose interrupt flag is set produces a one-cycle pulse on irq. Releasing one with the flag clear produces none.
- R7: irq_frame is high with irq exactly when the releasing descriptor had its last flag set.
- R8: Between two buffers of one frame, if the polled descriptor is not ready while out_ready is high, out_abort pulses in that cycle. The status of that descriptor becomes 10 (underrun), its ready flag stays clear, the frame is abandoned, and polling continues on the same descriptor, which later starts a fresh frame.
- R9: After a release, polling moves to descriptor 0 if the released descriptor had its wrap flag set or was the highest index. Otherwise it moves to the next index.
- R10: A ready descriptor of length 0 offers no byte. It is released one cycle after it is picked up if its last flag is clear, or when close_done is seen if its last flag is set.
- R11: A software descriptor write loads all its fields and clears its status to 00. It takes precedence over a release or underrun write-back to the same descriptor in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_en | input | 1 | Descriptor write strobe |
| cw_idx | input | IDX_W | Descriptor index to write |
| cw_ready | input | 1 | Ready flag value |
| cw_last | input | 1 | Last-buffer-of-frame flag value |
| cw_intr | input | 1 | Interrupt-on-release flag value |
| cw_wrap | input | 1 | Return-to-0 flag value |
| cw_len | input | LEN_W | Buffer length in bytes |
| cw_addr | input | ADDR_W | Buffer start address in the byte store |
| bw_en | input | 1 | Byte store write strobe |
| bw_addr | input | ADDR_W | Byte store write address |
| bw_data | input | 8 | Byte store write data |
| rd_idx | input | IDX_W | Descriptor index for read-back |
| rd_ready | output | 1 | Ready flag of descriptor rd_idx |
| rd_status | output | 2 | Status of descriptor rd_idx (01 sent, 10 underrun) |
| out_valid | output | 1 | Byte on offer to the framer |
| out_ready | input | 1 | Framer takes the byte / is asking for data |
| out_data | output | 8 | Byte offered |
| out_last | output | 1 | Offered byte ends the frame |
| out_abort | output | 1 | Underrun pulse: abandon current frame |
| close_done | input | 1 | Framer has sent the closing flag |
| irq | output | 1 | Release interrupt pulse |
| irq_frame | output | 1 | With irq: the released descriptor ended a frame |

## Verification
The bench builds the block with a 4-entry table, 4-bit lengths and a 64-byte store. The small table means that the forced return from the highest index, the wrap flag and the same-cycle collision of a software write with an underrun write-back all occur within a few hundred cycles. Lengths of 0 to 6 bytes, random framer back-pressure and a randomly timed close_done make zero-length buffers, multi-buffer frames and underruns between buffers frequent. A wrapping read window over the byte store is also covered.

// File: rtl/txbd_pkg.sv
package txbd_pkg;

  localparam int STAT_W = 2;
  localparam logic [STAT_W-1:0] STAT_SENT = 2'b01;
  localparam logic [STAT_W-1:0] STAT_UNDR = 2'b10;

  typedef enum logic [1:0] {
    ST_POLL,
    ST_SEND,
    ST_END,
    ST_CLOSE
  } seq_st_e;

  typedef struct packed {
    logic ready;
    logic last;
    logic intr;
    logic wrap;
  } bd_flags_t;

  // index that follows a released descriptor
  function automatic int unsigned bd_next(input int unsigned cur, input logic wrap,
                                          input int unsigned depth);
    return (wrap || cur == depth - 1) ? 0 : cur + 1;
  endfunction

  // true when byte number cnt is the final one of a len-byte buffer
  function automatic logic is_final(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) == len;
  endfunction

endpackage

// File: rtl/txbd_table.sv
module txbd_table import txbd_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  bd_flags_t         cw_flags,
  input  logic [LEN_W-1:0]  cw_len,
  input  logic [ADDR_W-1:0] cw_addr,
  input  logic              sq_we,
  input  logic              sq_stat_en,
  input  logic [STAT_W-1:0] sq_stat,
  input  logic [IDX_W-1:0]  sq_idx,
  output bd_flags_t         sq_flags,
  output logic [LEN_W-1:0]  sq_len,
  output logic [ADDR_W-1:0] sq_addr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_ready,
  output logic [STAT_W-1:0] rd_status
);

  bd_flags_t         flags_q [DEPTH];
  logic [LEN_W-1:0]  len_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [STAT_W-1:0] stat_q  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        flags_q[i] <= '0;
        len_q[i]   <= '0;
        addr_q[i]  <= '0;
        stat_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cw_en && cw_idx == IDX_W'(i)) begin
          flags_q[i] <= cw_flags;
          len_q[i]   <= cw_len;
          addr_q[i]  <= cw_addr;
          stat_q[i]  <= '0;
        end else if (sq_we && sq_idx == IDX_W'(i)) begin
          flags_q[i].ready <= 1'b0;
          if (sq_stat_en) stat_q[i] <= sq_stat;
        end
      end
    end
  end

  assign sq_flags  = flags_q[sq_idx];
  assign sq_len    = len_q[sq_idx];
  assign sq_addr   = addr_q[sq_idx];
  assign rd_ready  = flags_q[rd_idx].ready;
  assign rd_status = stat_q[rd_idx];

endmodule

// File: rtl/txbd_bytemem.sv
module txbd_bytemem #(
  parameter int ADDR_W = 8,
  localparam int WORDS = 2 ** ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  logic [7:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/txbd_fsm.sv
module txbd_fsm import txbd_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bd_flags_t         bd_flags,
  input  logic [LEN_W-1:0]  bd_len,
  input  logic [ADDR_W-1:0] bd_addr,
  input  logic              out_ready,
  input  logic              close_done,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              out_valid,
  output logic              out_last,
  output logic              out_abort,
  output logic              wb_we,
  output logic              wb_stat_en,
  output logic [STAT_W-1:0] wb_stat,
  output logic              irq,
  output logic              irq_frame,
  output logic              fin_evt,
  output logic              und_evt
);

  seq_st_e           st_q;
  logic [IDX_W-1:0]  cur_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              last_q, intr_q, wrap_q;
  logic              mid_q;
  logic              final_byte;
  logic              poll_hit;

  assign poll_hit   = (st_q == ST_POLL) && bd_flags.ready;
  assign und_evt    = (st_q == ST_POLL) && !bd_flags.ready && mid_q && out_ready;
  assign fin_evt    = (st_q == ST_END) || ((st_q == ST_CLOSE) && close_done);
  assign final_byte = is_final(32'(cnt_q), 32'(len_q));

  assign cur_idx    = cur_q;
  assign byte_addr  = base_q + ADDR_W'(cnt_q);
  assign out_valid  = (st_q == ST_SEND);
  assign out_last   = out_valid && last_q && final_byte;
  assign out_abort  = und_evt;

  assign wb_we      = fin_evt || und_evt;
  assign wb_stat_en = und_evt || (fin_evt && last_q);
  assign wb_stat    = und_evt ? STAT_UNDR : STAT_SENT;
  assign irq        = fin_evt && intr_q;
  assign irq_frame  = irq && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_POLL;
      cur_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
      intr_q <= 1'b0;
      wrap_q <= 1'b0;
      mid_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_POLL: begin
          if (poll_hit) begin
            base_q <= bd_addr;
            len_q  <= bd_len;
            cnt_q  <= '0;
            last_q <= bd_flags.last;
            intr_q <= bd_flags.intr;
            wrap_q <= bd_flags.wrap;
            if (bd_len == '0) st_q <= bd_flags.last ? ST_CLOSE : ST_END;
            else              st_q <= ST_SEND;
          end else if (und_evt) begin
            mid_q <= 1'b0;
          end
        end
        ST_SEND: begin
          if (out_ready) begin
            cnt_q <= cnt_q + 1'b1;
            if (final_byte) st_q <= last_q ? ST_CLOSE : ST_END;
          end
        end
        ST_END, ST_CLOSE: begin
          if (fin_evt) begin
            cur_q <= IDX_W'(bd_next(32'(cur_q), wrap_q, DEPTH));
            mid_q <= !last_q;
            st_q  <= ST_POLL;
          end
        end
        default: st_q <= ST_POLL;
      endcase
    end
  end

endmodule

// File: rtl/txbd_sequencer.sv
module txbd_sequencer import txbd_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  logic              cw_ready,
  input  logic              cw_last,
  input  logic              cw_intr,
  input  logic              cw_wrap,
  input  logic [LEN_W-1:0]  cw_len,
  input  logic [ADDR_W-1:0] cw_addr,
  input  logic              bw_en,
  input  logic [ADDR_W-1:0] bw_addr,
  input  logic [7:0]        bw_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_ready,
  output logic [1:0]        rd_status,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              out_abort,
  input  logic              close_done,
  output logic              irq,
  output logic              irq_frame
);

  bd_flags_t         cw_flags;
  bd_flags_t         cur_flags;
  logic [LEN_W-1:0]  cur_len;
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] byte_addr;
  logic              wb_we, wb_stat_en;
  logic [STAT_W-1:0] wb_stat;
  logic              fin_evt, und_evt;

  assign cw_flags = '{ready: cw_ready, last: cw_last, intr: cw_intr, wrap: cw_wrap};

  txbd_table #(.DEPTH(DEPTH), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw_en     (cw_en),
    .cw_idx    (cw_idx),
    .cw_flags  (cw_flags),
    .cw_len    (cw_len),
    .cw_addr   (cw_addr),
    .sq_we     (wb_we),
    .sq_stat_en(wb_stat_en),
    .sq_stat   (wb_stat),
    .sq_idx    (cur_idx),
    .sq_flags  (cur_flags),
    .sq_len    (cur_len),
    .sq_addr   (cur_addr),
    .rd_idx    (rd_idx),
    .rd_ready  (rd_ready),
    .rd_status (rd_status)
  );

  txbd_bytemem #(.ADDR_W(ADDR_W)) u_mem (
    .clk  (clk),
    .we   (bw_en),
    .waddr(bw_addr),
    .wdata(bw_data),
    .raddr(byte_addr),
    .rdata(out_data)
  );

  txbd_fsm #(.DEPTH(DEPTH), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bd_flags  (cur_flags),
    .bd_len    (cur_len),
    .bd_addr   (cur_addr),
    .out_ready (out_ready),
    .close_done(close_done),
    .cur_idx   (cur_idx),
    .byte_addr (byte_addr),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_abort (out_abort),
    .wb_we     (wb_we),
    .wb_stat_en(wb_stat_en),
    .wb_stat   (wb_stat),
    .irq       (irq),
    .irq_frame (irq_frame),
    .fin_evt   (fin_evt),
    .und_evt   (und_evt)
  );

endmodule

// File: rtl/txbd_sequencer_chk.sv
module txbd_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic out_valid,
  input logic out_ready,
  input logic out_last,
  input logic out_abort,
  input logic irq,
  input logic irq_frame,
  input logic fin_evt,
  input logic und_evt
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!out_valid && !irq && !out_abort)
        else $error("R1: activity during reset");
    end
  end

  assert_hold_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_last)));

  assert_last_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_release_excl_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fin_evt, und_evt}));

  assert_irq_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_only_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fin_evt);

  assert_frame_flag_with_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame |-> irq);

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> (out_ready && !out_valid && !irq));

endmodule

bind txbd_sequencer txbd_sequencer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_last (out_last),
  .out_abort(out_abort),
  .irq      (irq),
  .irq_frame(irq_frame),
  .fin_evt  (fin_evt),
  .und_evt  (und_evt)
);

// File: tb/txbd_sequencer_bench.sv
module txbd_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int LEN_W  = 4;
  localparam int ADDR_W = 6;
  localparam int IW     = 2;
  localparam int MSZ    = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cw_en = 1'b0;
  logic [IW-1:0]     cw_idx = '0;
  logic              cw_ready = 1'b0, cw_last = 1'b0, cw_intr = 1'b0, cw_wrap = 1'b0;
  logic [LEN_W-1:0]  cw_len = '0;
  logic [ADDR_W-1:0] cw_addr = '0;
  logic              bw_en = 1'b0;
  logic [ADDR_W-1:0] bw_addr = '0;
  logic [7:0]        bw_data = '0;
  logic [IW-1:0]     rd_idx = '0;
  logic              rd_ready;
  logic [1:0]        rd_status;
  logic              out_valid, out_last, out_abort, irq, irq_frame;
  logic [7:0]        out_data;
  logic              out_ready = 1'b0;
  logic              close_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txbd_sequencer #(.DEPTH(DEPTH), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_txbd_sequencer (
    .clk(clk), .rst_n(rst_n),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_ready(cw_ready), .cw_last(cw_last),
    .cw_intr(cw_intr), .cw_wrap(cw_wrap), .cw_len(cw_len), .cw_addr(cw_addr),
    .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
    .rd_idx(rd_idx), .rd_ready(rd_ready), .rd_status(rd_status),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_abort(out_abort), .close_done(close_done),
    .irq(irq), .irq_frame(irq_frame)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  // ---------------- behavioural reference model ----------------
  bit m_rdy [DEPTH], m_last [DEPTH], m_int [DEPTH], m_wrap [DEPTH];
  int m_len [DEPTH], m_addr [DEPTH], m_stat [DEPTH];
  int m_mem [MSZ];
  int ph;            // 0 waiting for a ready entry, 1 sending, 2 release, 3 await close
  int mcur, mbase, mlen, mcnt;
  bit mfl, mfi, mfw, mmid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; mcur = 0; mcnt = 0; mmid = 0; mbase = 0; mlen = 0;
      mfl = 0; mfi = 0; mfw = 0;
      for (int i = 0; i < DEPTH; i++) begin
        m_rdy[i] = 0; m_last[i] = 0; m_int[i] = 0; m_wrap[i] = 0;
        m_len[i] = 0; m_addr[i] = 0; m_stat[i] = 0;
      end
    end else begin
      if (ph == 0) begin
        if (m_rdy[mcur]) begin
          mbase = m_addr[mcur]; mlen = m_len[mcur]; mcnt = 0;
          mfl = m_last[mcur]; mfi = m_int[mcur]; mfw = m_wrap[mcur];
          ph = (mlen == 0) ? (mfl ? 3 : 2) : 1;
        end else if (mmid && out_ready) begin
          m_stat[mcur] = 2;
          mmid = 0;
        end
      end else if (ph == 1) begin
        if (out_ready) begin
          mcnt++;
          if (mcnt == mlen) ph = mfl ? 3 : 2;
        end
      end else if (ph == 2 || close_done) begin
        m_rdy[mcur] = 0;
        if (mfl) m_stat[mcur] = 1;
        mmid = !mfl;
        mcur = (mfw || mcur == DEPTH - 1) ? 0 : mcur + 1;
        ph = 0;
      end
      if (cw_en) begin
        m_rdy[cw_idx] = cw_ready; m_last[cw_idx] = cw_last;
        m_int[cw_idx] = cw_intr;  m_wrap[cw_idx] = cw_wrap;
        m_len[cw_idx] = int'(cw_len); m_addr[cw_idx] = int'(cw_addr);
        m_stat[cw_idx] = 0;
      end
      if (bw_en) m_mem[bw_addr] = int'(bw_data);
    end
  end

  // ---------------- framer side stimulus ----------------
  logic [31:0] lf1 = 32'h1234_5678;
  bit rdy_rand = 0;

  always @(negedge clk) begin
    lf1 = lfsr_step(lf1);
    out_ready  = rdy_rand ? (lf1[0] | lf1[3]) : 1'b1;
    close_done = (lf1[5:4] == 2'b00);
    rd_idx     = rd_idx + 1'b1;
  end

  // ---------------- per-cycle comparison ----------------
  bit e_valid, e_last, e_abort, e_irq, e_irqf, e_fin;
  int e_data;

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      e_valid = (ph == 1);
      e_data  = m_mem[(mbase + mcnt) % MSZ];
      e_last  = e_valid && mfl && (mcnt + 1 == mlen);
      e_abort = (ph == 0) && !m_rdy[mcur] && mmid && out_ready;
      e_fin   = (ph == 2) || (ph == 3 && close_done);
      e_irq   = e_fin && mfi;
      e_irqf  = e_irq && mfl;
      chk(out_valid == e_valid, "R2 R10 out_valid", out_valid, e_valid);
      if (e_valid) chk(int'(out_data) == e_data, "R2 R9 out_data", out_data, e_data);
      chk(out_last  == e_last,  "R3 out_last",   out_last,  e_last);
      chk(out_abort == e_abort, "R8 out_abort",  out_abort, e_abort);
      chk(irq       == e_irq,   "R6 irq",        irq,       e_irq);
      chk(irq_frame == e_irqf,  "R7 irq_frame",  irq_frame, e_irqf);
      chk(rd_ready  == m_rdy[rd_idx], "R4 R5 R11 rd_ready", rd_ready, m_rdy[rd_idx]);
      chk(int'(rd_status) == m_stat[rd_idx], "R5 R8 R11 rd_status", rd_status, m_stat[rd_idx]);
    end
  end

  // ---------------- software side tasks ----------------
  task automatic put_byte(input int a, input int d);
    @(negedge clk);
    bw_en = 1'b1; bw_addr = ADDR_W'(a); bw_data = 8'(d);
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic arm(input int idx, input bit l, input bit it, input bit w,
                     input int len, input int a);
    @(negedge clk);
    cw_en = 1'b1; cw_idx = IW'(idx); cw_ready = 1'b1; cw_last = l;
    cw_intr = it; cw_wrap = w; cw_len = LEN_W'(len); cw_addr = ADDR_W'(a);
    @(negedge clk);
    cw_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  logic [31:0] lf3 = 32'hCAFE_0001;
  int sw;

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(irq == 1'b0,       "R1 irq in reset",       irq, 0);
    chk(rd_ready == 1'b0,  "R1 ready in reset",     rd_ready, 0);
    chk(rd_status == 2'b00,"R1 status in reset",    rd_status, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < MSZ; a++) put_byte(a, (a * 7 + 3) & 8'hFF);
    repeat (10) @(negedge clk);
    // R1 R2: first frame comes from descriptor 0, single buffer
    arm(0, 1, 1, 0, 4, 2);
    repeat (30) @(negedge clk);
    // R4: two-buffer frame, second written first to avoid underrun
    arm(2, 1, 0, 0, 2, 20);
    arm(1, 0, 1, 0, 3, 10);
    repeat (30) @(negedge clk);
    // R8 R9: highest index then descriptor 0 not ready mid-frame -> underrun
    arm(3, 0, 1, 0, 2, 30);
    repeat (20) @(negedge clk);
    // R10: zero-length closing buffer restarts at descriptor 0
    arm(0, 1, 1, 0, 0, 0);
    repeat (20) @(negedge clk);
    // R9: wrap flag returns to descriptor 0; buffer window wraps the store
    arm(1, 1, 1, 1, 3, 62);
    repeat (20) @(negedge clk);
    arm(0, 1, 0, 0, 1, 50);
    repeat (20) @(negedge clk);
    // random phase: back-pressure, varied lengths, underruns, collisions (R11)
    rdy_rand = 1;
    sw = mcur;
    for (int it = 0; it < 3000; it++) begin
      @(negedge clk);
      lf3 = lfsr_step(lf3);
      if (lf3[1:0] == 2'b00 && !m_rdy[sw]) begin
        cw_en = 1'b1; cw_idx = IW'(sw); cw_ready = 1'b1;
        cw_last = lf3[8]; cw_intr = lf3[9]; cw_wrap = (lf3[12:10] == 3'b000);
        cw_len = LEN_W'(lf3[15:13] % 7); cw_addr = ADDR_W'(lf3[23:18]);
        sw = (cw_wrap || sw == DEPTH - 1) ? 0 : sw + 1;
      end else begin
        cw_en = 1'b0;
      end
    end
    @(negedge clk);
    cw_en = 1'b0;
    repeat (60) @(negedge clk);
    finish_run();
  end

endmodule